// File: doc/BRIEF.md
# Strobe-Handshake Bus Master

This block sits between a processor core and a non-multiplexed parallel bus. The bus has a 24-bit byte address and a 16-bit data path. The core asks for a transfer with a one-clock start pulse. The pulse carries a byte address, a size code (byte, word or long), a direction flag and up to 32 bits of write data. The block then runs one or two bus cycles. In each cycle it puts out the address, raises an address strobe together with the byte-lane strobes it needs, and waits for the slave's data acknowledge. It adds whole wait clocks until that acknowledge is sampled.

The two byte lanes are picked from address parity. The upper lane (bit 1 of the lane vector) serves even addresses and the lower lane (bit 0) serves odd addresses. A long transfer becomes two word cycles, lower address first, and the first cycle carries the upper half of the data. Word requests at odd addresses and long requests that are not 4-aligned never reach the bus. For those, the block reports a bus error one clock after the start. Every finished request, good or failed, returns a done pulse that lasts one clock.

Top module: `hsbm_bus_master`

## Requirements
- R1: The address on bus_addr is valid for one clock before bus_as rises, and stays unchanged while bus_as is high and through the release clock.
- R2: For a byte or word request whose acknowledge is present at the first sample, req_done is high in the 4th clock after the clock that samples req_start: address, strobe, sample, release.
- R3: Each clock in which the acknowledge is sampled low adds exactly one clock to the cycle, and the strobes stay asserted until the acknowledge is sampled high.
- R4: Size codes are 0 = byte, 1 = word, 2 = long. A byte access asserts only bus_lane[1] at an even address and only bus_lane[0] at an odd address. Word and long cycles assert both lanes, and bus_addr[0] stays as requested.
- R5: Read data is captured on the clock edge that samples the acknowledge. A byte read returns the selected lane's byte zero-extended in req_rdata[7:0]. A word read returns bus_din zero-extended. A byte write drives the byte on both halves of bus_dout.
- R6: A word request at an odd address asserts req_err together with req_done in the clock after the start. It never raises bus_as.
- R7: A long request whose address is not a multiple of four fails with req_err and no bus activity. So does size code 3. Both report in the same clock as in R6.
- R8: A long request runs two word cycles, at the request address and then at the address plus 2. The upper 16 bits of data travel in the first cycle: written from req_wdata[31:16], read into req_rdata[31:16]. With no waits, req_done appears in the 8th clock.
- R9: On a write, bus_dout holds its value from the address clock until the strobes are released.
- R10: req_done is high for exactly one clock per request, and req_err is never high without req_done.
- R11: A req_start pulse that arrives while a request is in progress is ignored. It produces no bus cycle and no done pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_start | input | 1 | One-clock request pulse from the core |
| req_addr | input | 24 | Byte address of the request |
| req_size | input | 2 | 0 byte, 1 word, 2 long, 3 invalid |
| req_write | input | 1 | 1 for write, 0 for read |
| req_wdata | input | 32 | Write data; byte in [7:0], word in [15:0] |
| req_done | output | 1 | One-clock completion pulse |
| req_err | output | 1 | Bus error, valid with req_done |
| req_rdata | output | 32 | Read data, valid from req_done onwards |
| bus_addr | output | 24 | Bus byte address |
| bus_as | output | 1 | Address strobe |
| bus_rnw | output | 1 | 1 read, 0 write |
| bus_lane | output | 2 | Byte-lane strobes; [1] even byte, [0] odd byte |
| bus_dout | output | 16 | Write data to the bus |
| bus_din | input | 16 | Read data from the bus |
| bus_ack | input | 1 | Data acknowledge from the slave |

## Verification
The assertions assume the slave raises bus_ack only while the strobes are high, and drops it once they are released. The R3 hold check and the R1 address check depend on that. They also assume a new req_start is presented only after reset is released. The bench slave model drives bus_ack and bus_din on the falling edge. It counts strobe clocks from the moment the lanes assert, and it releases everything as soon as the strobes fall. Random requests use per-beat wait counts of 0 to 3 and bias addresses towards the aligned cases, with misaligned and invalid-size requests mixed in on purpose.

// File: rtl/hsbm_pkg.sv
package hsbm_pkg;

    localparam int unsigned HS_ADDR_W = 24;
    localparam int unsigned HS_DATA_W = 16;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_WORD = 2'd1,
        SZ_LONG = 2'd2,
        SZ_BAD  = 2'd3
    } xfer_size_e;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_ADDR  = 3'd1,
        ST_STRB  = 3'd2,
        ST_SAMP  = 3'd3,
        ST_REL   = 3'd4,
        ST_FAULT = 3'd5
    } cyc_state_e;

    // Number of bus beats a well-formed request needs.
    function automatic logic needs_two(input xfer_size_e sz);
        return (sz == SZ_LONG);
    endfunction

    // States in which the block owns a bus cycle.
    function automatic logic in_cycle(input cyc_state_e st);
        return (st == ST_ADDR) || (st == ST_STRB) || (st == ST_SAMP) || (st == ST_REL);
    endfunction

    function automatic logic strobing(input cyc_state_e st);
        return (st == ST_STRB) || (st == ST_SAMP);
    endfunction

endpackage

// File: rtl/hsbm_req_check.sv
module hsbm_req_check
    import hsbm_pkg::*;
#(
    parameter int unsigned NLANE = 2,
    parameter int unsigned OFF_W = 1
) (
    input  xfer_size_e       size,
    input  logic [OFF_W:0]   low,
    output logic             fault,
    output logic             two_beats,
    output logic [NLANE-1:0] lanes
);

    logic [NLANE-1:0] byte_lanes;

    // Lane NLANE-1 carries offset 0 (even byte), lane 0 the highest offset.
    for (genvar i = 0; i < NLANE; i++) begin : g_lane
        assign byte_lanes[i] = (low[OFF_W-1:0] == OFF_W'(NLANE - 1 - i));
    end

    always_comb begin
        fault = 1'b0;
        lanes = {NLANE{1'b1}};
        unique case (size)
            SZ_BYTE: lanes = byte_lanes;
            SZ_WORD: fault = |low[OFF_W-1:0];
            SZ_LONG: fault = |low;
            default: fault = 1'b1;
        endcase
    end

    assign two_beats = needs_two(size);

endmodule

// File: rtl/hsbm_cycle_seq.sv
module hsbm_cycle_seq
    import hsbm_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic       fault,
    input  logic       two_beats,
    input  logic       bus_ack,
    output cyc_state_e state_q,
    output logic       beat_q,
    output logic       load,
    output logic       latch,
    output logic       done,
    output logic       err
);

    cyc_state_e state_d;
    logic       beat_d;
    logic       more;

    assign more = two_beats && !beat_q;

    always_comb begin
        state_d = state_q;
        beat_d  = beat_q;
        unique case (state_q)
            ST_IDLE: begin
                beat_d = 1'b0;
                if (start) state_d = fault ? ST_FAULT : ST_ADDR;
            end
            ST_ADDR: state_d = ST_STRB;
            ST_STRB: state_d = ST_SAMP;
            ST_SAMP: if (bus_ack) state_d = ST_REL;
            ST_REL: begin
                if (more) begin
                    state_d = ST_ADDR;
                    beat_d  = 1'b1;
                end else begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            beat_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            beat_q  <= beat_d;
        end
    end

    assign load  = (state_q == ST_IDLE) && start;
    assign latch = (state_q == ST_SAMP) && bus_ack;
    assign done  = ((state_q == ST_REL) && !more) || (state_q == ST_FAULT);
    assign err   = (state_q == ST_FAULT);

    AST_DONE_ONE_CLOCK: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R10

    AST_SECOND_BEAT_AFTER_RELEASE: assert property (@(posedge clk) disable iff (rst)
        $rose(beat_q) |-> $past(state_q) == ST_REL && state_q == ST_ADDR); // R8

endmodule

// File: rtl/hsbm_data_path.sv
module hsbm_data_path
    import hsbm_pkg::*;
#(
    parameter int unsigned DATA_W = 16,
    parameter int unsigned NLANE  = 2,
    parameter int unsigned OFF_W  = 1
) (
    input  logic                clk,
    input  logic                rst,
    input  xfer_size_e          size,
    input  logic [OFF_W-1:0]    off,
    input  logic                beat,
    input  logic [2*DATA_W-1:0] wdata,
    input  logic                latch,
    input  logic [DATA_W-1:0]   din,
    output logic [DATA_W-1:0]   dout,
    output logic [2*DATA_W-1:0] rdata
);

    localparam int unsigned LW = 2 * DATA_W;

    logic [7:0] byte_sel;

    always_comb begin
        unique case (size)
            SZ_BYTE: dout = {NLANE{wdata[7:0]}};
            SZ_LONG: dout = beat ? wdata[DATA_W-1:0] : wdata[LW-1:DATA_W];
            default: dout = wdata[DATA_W-1:0];
        endcase
    end

    always_comb begin
        byte_sel = 8'h00;
        for (int i = 0; i < NLANE; i++) begin
            if (off == OFF_W'(NLANE - 1 - i)) byte_sel = din[i*8 +: 8];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata <= '0;
        end else if (latch) begin
            unique case (size)
                SZ_BYTE: rdata <= {{(LW-8){1'b0}}, byte_sel};
                SZ_LONG: begin
                    if (beat) rdata[DATA_W-1:0]  <= din;
                    else      rdata[LW-1:DATA_W] <= din;
                end
                default: rdata <= {{DATA_W{1'b0}}, din};
            endcase
        end
    end

    AST_RDATA_ONLY_ON_ACK: assert property (@(posedge clk) disable iff (rst)
        !latch |=> $stable(rdata)); // R5

endmodule

// File: rtl/hsbm_bus_master.sv
module hsbm_bus_master
    import hsbm_pkg::*;
#(
    parameter int unsigned ADDR_W = HS_ADDR_W,
    parameter int unsigned DATA_W = HS_DATA_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                req_start,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic [1:0]          req_size,
    input  logic                req_write,
    input  logic [2*DATA_W-1:0] req_wdata,
    output logic                req_done,
    output logic                req_err,
    output logic [2*DATA_W-1:0] req_rdata,
    output logic [ADDR_W-1:0]   bus_addr,
    output logic                bus_as,
    output logic                bus_rnw,
    output logic [DATA_W/8-1:0] bus_lane,
    output logic [DATA_W-1:0]   bus_dout,
    input  logic [DATA_W-1:0]   bus_din,
    input  logic                bus_ack
);

    localparam int unsigned NLANE = DATA_W / 8;
    localparam int unsigned OFF_W = $clog2(NLANE);
    localparam int unsigned LW    = 2 * DATA_W;

    xfer_size_e       in_size;
    logic             dec_fault;
    logic             dec_two;
    logic [NLANE-1:0] dec_lanes;

    cyc_state_e       state_q;
    logic             beat_q;
    logic             load;
    logic             latch;

    logic [ADDR_W-1:0] r_addr;
    xfer_size_e        r_size;
    logic              r_write;
    logic [LW-1:0]     r_wdata;
    logic [NLANE-1:0]  r_lanes;
    logic              r_two;

    assign in_size = xfer_size_e'(req_size);

    hsbm_req_check #(.NLANE(NLANE), .OFF_W(OFF_W)) u_check (
        .size      (in_size),
        .low       (req_addr[OFF_W:0]),
        .fault     (dec_fault),
        .two_beats (dec_two),
        .lanes     (dec_lanes)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            r_addr  <= '0;
            r_size  <= SZ_BYTE;
            r_write <= 1'b0;
            r_wdata <= '0;
            r_lanes <= '0;
            r_two   <= 1'b0;
        end else if (load) begin
            r_addr  <= req_addr;
            r_size  <= in_size;
            r_write <= req_write;
            r_wdata <= req_wdata;
            r_lanes <= dec_lanes;
            r_two   <= dec_two;
        end
    end

    hsbm_cycle_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .start     (req_start),
        .fault     (dec_fault),
        .two_beats (r_two),
        .bus_ack   (bus_ack),
        .state_q   (state_q),
        .beat_q    (beat_q),
        .load      (load),
        .latch     (latch),
        .done      (req_done),
        .err       (req_err)
    );

    hsbm_data_path #(.DATA_W(DATA_W), .NLANE(NLANE), .OFF_W(OFF_W)) u_data (
        .clk   (clk),
        .rst   (rst),
        .size  (r_size),
        .off   (r_addr[OFF_W-1:0]),
        .beat  (beat_q),
        .wdata (r_wdata),
        .latch (latch),
        .din   (bus_din),
        .dout  (bus_dout),
        .rdata (req_rdata)
    );

    assign bus_addr = r_addr + (beat_q ? ADDR_W'(NLANE) : {ADDR_W{1'b0}});
    assign bus_as   = strobing(state_q);
    assign bus_lane = strobing(state_q) ? r_lanes : {NLANE{1'b0}};
    assign bus_rnw  = !(r_write && in_cycle(state_q));

    AST_ADDR_BEFORE_STROBE: assert property (@(posedge clk) disable iff (rst)
        $rose(bus_as) |-> $stable(bus_addr)); // R1

    AST_ADDR_HELD_IN_STROBE: assert property (@(posedge clk) disable iff (rst)
        bus_as |=> $stable(bus_addr)); // R1

    AST_WAIT_KEEPS_STROBE: assert property (@(posedge clk) disable iff (rst)
        (bus_as && !bus_ack) |=> (bus_as && $stable(bus_lane))); // R3

    for (genvar i = 0; i < NLANE; i++) begin : g_lane_chk
        AST_LANE_PARITY: assert property (@(posedge clk) disable iff (rst)
            (bus_as && $countones(bus_lane) == 1 && bus_lane[i])
                |-> bus_addr[OFF_W-1:0] == OFF_W'(NLANE - 1 - i)); // R4
    end

    AST_STROBE_HAS_LANE: assert property (@(posedge clk) disable iff (rst)
        bus_as |-> bus_lane != '0); // R4

    AST_FAULT_NO_BUS: assert property (@(posedge clk) disable iff (rst)
        req_err |-> (!bus_as && !$past(bus_as))); // R6

    AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (rst)
        req_err |-> req_done); // R10

    AST_WDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
        (bus_as && !bus_rnw) |=> $stable(bus_dout)); // R9

    AST_WDATA_READY_AT_STROBE: assert property (@(posedge clk) disable iff (rst)
        ($rose(bus_as) && !bus_rnw) |-> $stable(bus_dout)); // R9

endmodule

// File: tb/hsbm_bus_master_tb_top.sv
`timescale 1ns/1ps
module hsbm_bus_master_tb_top;

    localparam int AW = 24;
    localparam int DW = 16;
    localparam int LW = 32;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_start = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [1:0]    req_size = 2'd0;
    logic          req_write = 1'b0;
    logic [LW-1:0] req_wdata = '0;
    logic          req_done;
    logic          req_err;
    logic [LW-1:0] req_rdata;
    logic [AW-1:0] bus_addr;
    logic          bus_as;
    logic          bus_rnw;
    logic [1:0]    bus_lane;
    logic [DW-1:0] bus_dout;
    logic [DW-1:0] bus_din = '0;
    logic          bus_ack = 1'b0;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    hsbm_bus_master dut_i (
        .clk(clk), .rst(rst),
        .req_start(req_start), .req_addr(req_addr), .req_size(req_size),
        .req_write(req_write), .req_wdata(req_wdata),
        .req_done(req_done), .req_err(req_err), .req_rdata(req_rdata),
        .bus_addr(bus_addr), .bus_as(bus_as), .bus_rnw(bus_rnw),
        .bus_lane(bus_lane), .bus_dout(bus_dout),
        .bus_din(bus_din), .bus_ack(bus_ack)
    );

    // Slave model: memory content is a function of the word address.
    function automatic logic [15:0] mem_fn(input logic [23:0] a);
        logic [15:0] m;
        m = a[16:1] * 16'h9E37;
        return m ^ {8'h00, a[23:16]};
    endfunction

    int          w1 = 0;
    int          w2 = 0;
    int          s_cnt = 0;
    int          s_beat = 0;
    bit          s_logged = 0;
    int          as_seen = 0;
    int          log_n = 0;
    logic [23:0] log_addr [4];
    logic [1:0]  log_lane [4];
    logic        log_rnw  [4];
    logic [15:0] log_dout [4];

    always @(negedge clk) begin
        if (bus_as && bus_lane != 2'b00) begin
            s_cnt   = s_cnt + 1;
            as_seen = as_seen + 1;
            bus_din = mem_fn(bus_addr);
            bus_ack = (s_cnt >= 2 + ((s_beat == 0) ? w1 : w2));
            if (bus_ack && !s_logged && log_n < 4) begin
                log_addr[log_n] = bus_addr;
                log_lane[log_n] = bus_lane;
                log_rnw[log_n]  = bus_rnw;
                log_dout[log_n] = bus_dout;
                log_n    = log_n + 1;
                s_logged = 1;
            end
        end else begin
            if (s_cnt != 0) s_beat = s_beat + 1;
            s_cnt    = 0;
            bus_ack  = 1'b0;
            s_logged = 0;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic bit exp_fault(input logic [23:0] a, input logic [1:0] sz);
        case (sz)
            2'd0:    return 1'b0;
            2'd1:    return a[0];
            2'd2:    return a[1:0] != 2'b00;
            default: return 1'b1;
        endcase
    endfunction

    function automatic logic [31:0] exp_rd(input logic [23:0] a, input logic [1:0] sz);
        logic [15:0] m;
        m = mem_fn(a);
        case (sz)
            2'd0:    return a[0] ? {24'h0, m[7:0]} : {24'h0, m[15:8]};
            2'd1:    return {16'h0, m};
            default: return {m, mem_fn(a + 24'd2)};
        endcase
    endfunction

    task automatic run_req(input logic [23:0] a, input logic [1:0] sz, input bit wr,
                           input logic [31:0] wd, input int wa, input int wb,
                           input bit poke, input string tag);
        bit          f;
        int          beats;
        int          exp_lat;
        int          lat;
        int          as_before;
        logic [15:0] ed;
        logic [1:0]  el;
        f       = exp_fault(a, sz);
        beats   = f ? 0 : ((sz == 2'd2) ? 2 : 1);
        exp_lat = f ? 1 : ((sz == 2'd2) ? 8 + wa + wb : 4 + wa);
        @(negedge clk);
        w1 = wa; w2 = wb; log_n = 0; s_beat = 0; as_seen = 0;
        req_addr = a; req_size = sz; req_write = wr; req_wdata = wd;
        req_start = 1'b1;
        @(negedge clk);
        req_start = 1'b0;
        lat = 1;
        while (!req_done && lat < 64) begin
            if (poke && lat == 2) begin
                req_start = 1'b1;
                req_addr  = a ^ 24'h000100;
            end else begin
                req_start = 1'b0;
            end
            @(negedge clk);
            lat++;
        end
        req_start = 1'b0;
        // R2 R3 R8: completion clock
        chk(lat == exp_lat, f ? "R6" : ((sz == 2'd2) ? "R8" : ((wa == 0) ? "R2" : "R3")),
            {tag, " latency"}, lat, exp_lat);
        chk(req_err == f, (sz == 2'd2 || sz == 2'd3) ? "R7" : "R6", {tag, " err"}, req_err, f);
        if (f) begin
            chk(as_seen == 0, (sz == 2'd1) ? "R6" : "R7", {tag, " no strobe on fault"}, as_seen, 0);
        end else begin
            chk(log_n == beats, "R8", {tag, " beat count"}, log_n, beats);
            if (!wr)
                chk(req_rdata == exp_rd(a, sz), (sz == 2'd2) ? "R8" : "R5",
                    {tag, " read data"}, req_rdata, exp_rd(a, sz));
            for (int k = 0; k < beats && k < log_n; k++) begin
                el = (sz == 2'd0) ? (a[0] ? 2'b01 : 2'b10) : 2'b11;
                chk(log_addr[k] == a + 24'(2 * k), "R1", {tag, " bus address"},
                    log_addr[k], a + 24'(2 * k));
                chk(log_lane[k] == el, "R4", {tag, " lanes"}, log_lane[k], el);
                chk(log_rnw[k] == !wr, "R1", {tag, " direction"}, log_rnw[k], !wr);
                if (wr) begin
                    if (sz == 2'd0)      ed = {wd[7:0], wd[7:0]};
                    else if (sz == 2'd1) ed = wd[15:0];
                    else                 ed = (k == 0) ? wd[31:16] : wd[15:0];
                    chk(log_dout[k] == ed, (sz == 2'd2) ? "R8" : ((sz == 2'd0) ? "R5" : "R9"),
                        {tag, " write data"}, log_dout[k], ed);
                end
            end
        end
        @(negedge clk);
        chk(req_done == 1'b0, "R10", {tag, " done one clock"}, req_done, 0);
        if (poke) begin
            as_before = as_seen;
            for (int k = 0; k < 6; k++) begin
                @(negedge clk);
                chk(req_done == 1'b0 && as_seen == as_before, "R11",
                    {tag, " ignored start"}, {req_done, 8'(as_seen)}, {1'b0, 8'(as_before)});
            end
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [23:0] ra;
        logic [1:0]  rs;
        void'($urandom(32'd1957));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(!bus_as && bus_lane == 2'b00 && !req_done && !req_err, "R10", "reset state",
            {bus_as, bus_lane, req_done, req_err}, 0);

        run_req(24'h001234, 2'd1, 1'b0, 32'h0,        0, 0, 0, "word read");
        run_req(24'h00ABC0, 2'd0, 1'b0, 32'h0,        0, 0, 0, "byte read even");
        run_req(24'h00ABC1, 2'd0, 1'b0, 32'h0,        2, 0, 0, "byte read odd");
        run_req(24'h100002, 2'd0, 1'b1, 32'h000000A7, 0, 0, 0, "byte write even");
        run_req(24'h100003, 2'd0, 1'b1, 32'h0000005C, 1, 0, 0, "byte write odd");
        run_req(24'h200010, 2'd1, 1'b1, 32'h0000BEEF, 3, 0, 0, "word write waits");
        run_req(24'h300020, 2'd2, 1'b0, 32'h0,        0, 0, 0, "long read");
        run_req(24'h300040, 2'd2, 1'b1, 32'hCAFE1234, 1, 3, 0, "long write waits");
        run_req(24'hFFFFFC, 2'd2, 1'b0, 32'h0,        2, 1, 0, "long read top");
        run_req(24'h000101, 2'd1, 1'b0, 32'h0,        0, 0, 0, "word odd");
        run_req(24'h000102, 2'd2, 1'b1, 32'h11112222, 0, 0, 0, "long half aligned");
        run_req(24'h000103, 2'd2, 1'b0, 32'h0,        0, 0, 0, "long odd");
        run_req(24'h000200, 2'd3, 1'b0, 32'h0,        0, 0, 0, "bad size");
        run_req(24'h000300, 2'd1, 1'b0, 32'h0,        1, 0, 1, "start while busy");
        run_req(24'h000400, 2'd2, 1'b1, 32'h89ABCDEF, 0, 2, 1, "start while long busy");

        for (int n = 0; n < 80; n++) begin
            ra = 24'($urandom);
            rs = 2'($urandom_range(0, 3));
            if ($urandom_range(0, 9) < 8) ra[1:0] = (rs == 2'd0) ? ra[1:0] : 2'b00;
            if (rs == 2'd3 && $urandom_range(0, 3) != 0) rs = 2'($urandom_range(0, 2));
            run_req(ra, rs, 1'($urandom), $urandom, $urandom_range(0, 3),
                    $urandom_range(0, 3), 0, "random");
        end

        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule